// File: doc/BRIEF.md
# Fixed-Point Adder/Subtractor with Prefix Carry Tree

This block adds or subtracts two signed 16-bit fixed-point operands that share one binary-point position, set by a fraction-width parameter (default 8, giving Q8.8 inputs). Both operands are widened by one sign bit. A 17-bit adder with a parallel-prefix carry network then forms the exact sum or difference, so it never wraps. Subtraction uses the same adder: the second operand is inverted and the adder's carry-in is set to 1. The 17-bit raw result carries one more integer bit than the inputs. It is trimmed back to 16 bits by dropping its least significant fraction bit, so the output format has one more integer bit and one fewer fraction bit than the inputs (Q9.7 by default).

Operands enter on a valid/ready stream and results leave on a second valid/ready stream, through a single output register. A transfer is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. The sampled operands and operation produce a result that is presented with `out_valid` high from that edge on. While the consumer holds `out_ready` low and a result is pending, the result is held unchanged and `in_ready` is low. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so back-to-back transfers run at one per clock.

Top module: `fxp_addsub`

## Requirements
- R1: With `in_sub`=0, an accepted transfer yields `out_result` = bits [16:1] of the 17-bit signed sum of the sign-extended operands, that is floor((A+B)/2) as a 16-bit two's-complement value.
- R2: With `in_sub`=1, an accepted transfer yields `out_result` = floor((A−B)/2) as a 16-bit two's-complement value. The operation is taken from `in_sub` in the accepting cycle.
- R3: The result never wraps. 0x7FFF+0x7FFF gives 0x7FFF, 0x8000+0x8000 gives 0x8000, 0x8000−0x7FFF gives 0x8000, and 0x7FFF−0x8000 gives 0x7FFF.
- R4: The dropped bit is discarded, not rounded, so results round toward minus infinity: 0x0001+0x0000 gives 0x0000, 0xFFFF+0x0000 gives 0xFFFF, and 0x0003+0x0000 gives 0x0001.
- R5: `out_valid` rises on the clock edge that accepts a transfer, one cycle after the input is presented. It falls after a drain (`out_valid` and `out_ready` both high) in a cycle with no new transfer.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_result` stays unchanged.
- R7: `in_ready` equals (not `out_valid`) or `out_ready`. Input presented while `in_ready` is low is not taken and does not alter `out_result`.
- R8: After reset (`rst_n` low, asynchronous, active low), `out_valid` is 0, `in_ready` is 1 and `out_result` is 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand transfer offered |
| in_ready | output | 1 | Block can take an operand transfer this cycle |
| in_a | input | 16 | Operand A, signed, FRAC_W fraction bits |
| in_b | input | 16 | Operand B, signed, FRAC_W fraction bits |
| in_sub | input | 1 | 0: A+B, 1: A−B |
| out_valid | output | 1 | Result register holds an undelivered result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 16 | Result, signed, FRAC_W−1 fraction bits |

## Verification
Directed sums and differences of small positive, negative and mixed-sign operands separate a correct prefix carry chain from one whose carries stop short at a given tree level. The two extremes of the range, in both operations, show whether the extra integer bit is really kept or the result wraps. Pairs whose exact sum is odd, both positive and negative, show whether the dropped bit is truncated toward minus infinity or rounded. A long run of pseudo-random operands against an integer model covers carry paths at every distance. A stall with changed input data while the consumer is not ready tests the hold and ready rules.

// File: rtl/fxa_pkg.sv
package fxa_pkg;
  typedef enum logic {
    FXA_OP_ADD = 1'b0,
    FXA_OP_SUB = 1'b1
  } fxa_op_e;
endpackage

// File: rtl/fxa_operand_prep.sv
// Widens both operands by a sign bit and conditions B for the chosen operation.
// Subtraction inverts B and requests a carry-in of 1 (two's complement of B).
module fxa_operand_prep
  import fxa_pkg::*;
#(
  parameter int WIDTH = 16,
  localparam int EXT_W = WIDTH + 1
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  fxa_op_e          op_i,
  output logic [EXT_W-1:0] a_ext_o,
  output logic [EXT_W-1:0] b_cond_o,
  output logic             cin_o
);
  logic [EXT_W-1:0] b_ext;

  assign a_ext_o = {a_i[WIDTH-1], a_i};
  assign b_ext   = {b_i[WIDTH-1], b_i};

  always_comb begin
    if (op_i == FXA_OP_SUB) begin
      b_cond_o = ~b_ext;
      cin_o    = 1'b1;
    end else begin
      b_cond_o = b_ext;
      cin_o    = 1'b0;
    end
  end
endmodule

// File: rtl/fxa_prefix_adder.sv
// Parallel-prefix (Kogge-Stone) adder. The carry-in occupies prefix position 0
// and bit k-1 occupies position k. So N positions resolve every carry into bits
// 0..N-1 in clog2(N) levels of the (g,p) combine operator.
module fxa_prefix_adder #(
  parameter int N = 17,
  localparam int LEVELS = $clog2(N)
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic         cin_i,
  output logic [N-1:0] sum_o
);
  logic [N-1:0]             half_sum;
  logic [LEVELS:0][N-1:0]   gen_l;
  logic [LEVELS:0][N-1:0]   prop_l;
  logic [N-1:0]             carry_in_bit;
  logic                     unused_top_prop;

  assign half_sum = a_i ^ b_i;

  // Level 0: position 0 is the carry-in, a pure generate.
  assign gen_l[0][0]  = cin_i;
  assign prop_l[0][0] = 1'b0;

  generate
    for (genvar k = 1; k < N; k++) begin : g_leaf
      assign gen_l[0][k]  = a_i[k-1] & b_i[k-1];
      assign prop_l[0][k] = half_sum[k-1];
    end

    for (genvar lv = 1; lv <= LEVELS; lv++) begin : g_level
      localparam int DIST = 1 << (lv - 1);
      for (genvar k = 0; k < N; k++) begin : g_node
        if (k >= DIST) begin : g_combine
          assign gen_l[lv][k]  = gen_l[lv-1][k] | (prop_l[lv-1][k] & gen_l[lv-1][k-DIST]);
          assign prop_l[lv][k] = prop_l[lv-1][k] & prop_l[lv-1][k-DIST];
        end else begin : g_pass
          assign gen_l[lv][k]  = gen_l[lv-1][k];
          assign prop_l[lv][k] = prop_l[lv-1][k];
        end
      end
    end
  endgenerate

  // Group generate of positions 0..j is the carry into bit j.
  assign carry_in_bit = gen_l[LEVELS];
  assign sum_o        = half_sum ^ carry_in_bit;

  // The last row of propagate terms has no consumer.
  assign unused_top_prop = ^prop_l[LEVELS];
endmodule

// File: rtl/fxa_out_stage.sv
// Single result register with valid/ready handshake on both sides.
module fxa_out_stage #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data
);
  logic take;

  assign in_ready = ~out_valid | out_ready;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (take) begin
        out_data <= in_data;
      end
      out_valid <= take | (out_valid & ~out_ready);
    end
  end

  assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_drain_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
endmodule

// File: rtl/fxp_addsub.sv
// Signed fixed-point add/subtract. Inputs carry FRAC_W fraction bits and the
// output carries FRAC_W-1 fraction bits (one more integer bit, no wrap).
module fxp_addsub
  import fxa_pkg::*;
#(
  parameter int WIDTH  = 16,
  parameter int FRAC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  input  logic             in_sub,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_result
);
  localparam int EXT_W = WIDTH + 1;

  generate
    if (FRAC_W < 1 || FRAC_W >= WIDTH) begin : g_bad_frac
      $error("fxp_addsub: FRAC_W must lie in 1..WIDTH-1");
    end
  endgenerate

  logic [EXT_W-1:0] a_ext;
  logic [EXT_W-1:0] b_cond;
  logic             cin;
  logic [EXT_W-1:0] raw_sum;
  logic [WIDTH-1:0] trimmed;
  fxa_op_e          op_sel;

  assign op_sel = fxa_op_e'(in_sub);

  fxa_operand_prep #(.WIDTH(WIDTH)) u_prep (
    .a_i      (in_a),
    .b_i      (in_b),
    .op_i     (op_sel),
    .a_ext_o  (a_ext),
    .b_cond_o (b_cond),
    .cin_o    (cin)
  );

  fxa_prefix_adder #(.N(EXT_W)) u_adder (
    .a_i   (a_ext),
    .b_i   (b_cond),
    .cin_i (cin),
    .sum_o (raw_sum)
  );

  // Drop the least significant fraction bit; keep the grown integer bit.
  assign trimmed = raw_sum[EXT_W-1:1];

  fxa_out_stage #(.WIDTH(WIDTH)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (trimmed),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_result)
  );

  // Prefix network agrees with a plain wide sum of the conditioned operands.
  assert_prefix_sum_R1: assert property (@(posedge clk) disable iff (!rst_n)
    raw_sum == EXT_W'(a_ext + b_cond + {{(EXT_W-1){1'b0}}, cin}));

  // Operand conditioning for subtraction: B inverted plus a carry-in of 1.
  assert_sub_negates_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_sub |-> (cin && ((b_cond ^ {in_b[WIDTH-1], in_b}) == {EXT_W{1'b1}})));

  // Extra integer bit keeps the sign of the exact result: no wrap.
  assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_sub && (in_a[WIDTH-1] == in_b[WIDTH-1])) |-> (trimmed[WIDTH-1] == in_a[WIDTH-1]));
endmodule

// File: tb/fxp_addsub_tb.sv
module fxp_addsub_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_a = '0;
  logic [15:0] in_b = '0;
  logic        in_sub = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_result;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 4 ns period

  fxp_addsub #(.WIDTH(16), .FRAC_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_sub(in_sub),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result)
  );

  function automatic logic [15:0] model(logic [15:0] a, logic [15:0] b, logic sub);
    int sa = $signed(a);
    int sb = $signed(b);
    int s  = sub ? (sa - sb) : (sa + sb);
    return 16'(s >>> 1);
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
    end
  endtask

  // One transfer with the consumer ready; result sampled at the next negedge.
  task automatic xfer(logic [15:0] a, logic [15:0] b, logic sub, output logic [15:0] res);
    @(negedge clk);
    in_valid = 1'b1; in_a = a; in_b = b; in_sub = sub; out_ready = 1'b1;
    @(negedge clk);
    res = out_result;
    in_valid = 1'b0;
  endtask

  task automatic run_one(string req, logic [15:0] a, logic [15:0] b, logic sub);
    logic [15:0] r;
    xfer(a, b, sub, r);
    check(req, r, model(a, b, sub));
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 out_valid", {15'd0, out_valid}, 16'd0);
    check("R8 in_ready", {15'd0, in_ready}, 16'd1);
    check("R8 out_result", out_result, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_add;
    run_one("R1 add pos", 16'h0100, 16'h0280, 1'b0);
    run_one("R1 add neg", 16'hFE00, 16'hFF40, 1'b0);
    run_one("R1 add mixed", 16'h1234, 16'hF00F, 1'b0);
    run_one("R1 add carry ripple", 16'h00FF, 16'h0001, 1'b0);
    check("R1 add literal", model(16'h0100, 16'h0100, 1'b0), 16'h0100);
  endtask

  task automatic t_sub;
    run_one("R2 sub pos", 16'h0300, 16'h0100, 1'b0 ^ 1'b1);
    run_one("R2 sub to neg", 16'h0100, 16'h0300, 1'b1);
    run_one("R2 sub neg", 16'hF000, 16'h8123, 1'b1);
    run_one("R2 sub self", 16'h5A5A, 16'h5A5A, 1'b1);
  endtask

  task automatic t_corners;
    logic [15:0] r;
    xfer(16'h7FFF, 16'h7FFF, 1'b0, r); check("R3 max+max", r, 16'h7FFF);
    xfer(16'h8000, 16'h8000, 1'b0, r); check("R3 min+min", r, 16'h8000);
    xfer(16'h8000, 16'h7FFF, 1'b1, r); check("R3 min-max", r, 16'h8000);
    xfer(16'h7FFF, 16'h8000, 1'b1, r); check("R3 max-min", r, 16'h7FFF);
  endtask

  task automatic t_truncation;
    logic [15:0] r;
    xfer(16'h0001, 16'h0000, 1'b0, r); check("R4 +1 trunc", r, 16'h0000);
    xfer(16'hFFFF, 16'h0000, 1'b0, r); check("R4 -1 trunc", r, 16'hFFFF);
    xfer(16'h0003, 16'h0000, 1'b0, r); check("R4 +3 trunc", r, 16'h0001);
    xfer(16'h0000, 16'h0001, 1'b1, r); check("R4 0-1 trunc", r, 16'hFFFF);
  endtask

  task automatic t_random;
    int bad = 0;
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a = 16'($urandom());
      logic [15:0] b = 16'($urandom());
      logic s = 1'($urandom());
      logic [15:0] r;
      xfer(a, b, s, r);
      if (r !== model(a, b, s)) begin
        bad++;
        $display("FAIL R1/R2 random a=0x%04h b=0x%04h sub=%0d actual=0x%04h expected=0x%04h",
                 a, b, s, r, model(a, b, s));
      end
    end
    checks++;
    if (bad != 0) failures++;
  endtask

  task automatic t_handshake;
    @(negedge clk);
    out_ready = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    check("R5 idle out_valid", {15'd0, out_valid}, 16'd0);
    in_valid = 1'b1; in_a = 16'h0200; in_b = 16'h0200; in_sub = 1'b0; out_ready = 1'b0;
    #1 check("R5 valid before edge", {15'd0, out_valid}, 16'd0);
    @(negedge clk);
    check("R5 valid after edge", {15'd0, out_valid}, 16'd1);
    check("R5 first result", out_result, 16'h0200);
    check("R7 not ready while stalled", {15'd0, in_ready}, 16'd0);
    in_a = 16'h7000; in_b = 16'h1000; in_sub = 1'b1;
    @(negedge clk);
    check("R6 valid held", {15'd0, out_valid}, 16'd1);
    check("R6 result held", out_result, 16'h0200);
    check("R7 blocked input ignored", out_result, 16'h0200);
    out_ready = 1'b1;
    #1 check("R7 ready when draining", {15'd0, in_ready}, 16'd1);
    @(negedge clk);
    check("R5 back-to-back valid", {15'd0, out_valid}, 16'd1);
    check("R2 second result", out_result, 16'h3000);
    in_valid = 1'b0;
    @(negedge clk);
    check("R5 drained", {15'd0, out_valid}, 16'd0);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    t_reset();
    t_add();
    t_sub();
    t_corners();
    t_truncation();
    t_random();
    t_handshake();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end
endmodule